// File: doc/BRIEF.md
# Change-of-flow trace filter

This block sits between a processor's change-of-flow event stream and a circular trace memory. Each incoming beat carries an address and a two-bit kind: source, destination or vector. The block decides whether the beat becomes a trace row. When it does, the block writes the address with its kind tag at the current write slot through a registered RAM write port, and it reports the write pointer, the number of valid rows and whether the ring has wrapped.

In normal mode every legal beat taken while tracing is armed is written. In loop-filter mode a source beat is dropped when its address equals the last row stored. That row may be of any kind. Tight polling or delay loops therefore leave one row instead of filling the ring. Destination and vector beats are never filtered, because a repeated destination or vector usually points at a fault worth seeing. Raising the arm input starts a fresh capture. The pointer, the count and the wrap flag return to zero and the last-stored register is invalidated.

The input stream is valid/ready, but there is no back-pressure. `cof_ready` is held high, so every beat with `cof_valid` high is taken on that clock edge, whether it is written or dropped. The producer never has to wait. The RAM side has no handshake: the memory must accept one write per cycle.

Top module: `cof_trace_filter`

## Requirements
- R1: `cof_ready` is high in every cycle, including during reset, and a beat is taken on each clock edge where `cof_valid` is high.
- R2: A beat that is written appears on the RAM port one cycle after it was taken: `ram_we` is high, `ram_waddr` is the write slot at the time it was taken, and `ram_wdata` is `{kind, addr}` with the kind in the top two bits. The kind codes are 01 = source, 10 = destination and 11 = vector. With `cof_valid` low, nothing is written.
- R3: With `loop_filter` high, a source beat whose address equals the last row written since arming is dropped. `ram_we` stays low and the pointer does not move.
- R4: Destination and vector beats are written even when they repeat the previous row. Every row written, of any kind, becomes the last-stored value that R3 compares against.
- R5: With `loop_filter` low, every legal beat taken while armed is written, including repeated sources.
- R6: While `arm` is low, beats are taken but not written, and `wr_ptr`, `entry_count` and `wrapped` hold their values.
- R7: In the cycle where `arm` rises, the pointer, the count and the wrap flag restart from zero and the last-stored register is invalid. A beat in that cycle is written to slot 0, even if it is a source that matches the old last-stored address.
- R8: `wr_ptr` advances by one for each write, modulo DEPTH. `wrapped` goes high on the write to slot DEPTH-1 and stays high until re-arm or reset.
- R9: `entry_count` increases by one for each write and saturates at DEPTH.
- R10: While and after reset, `ram_we`, `wr_ptr`, `entry_count` and `wrapped` are zero, and the first beat written after reset goes to slot 0.
- R11: A beat with kind code 00 (reserved) is never written and never updates the last-stored register.
- R12: Written beats take consecutive slots in arrival order. For example, an interrupt during a jump gives the destination, then the vector, then the return destination, then later sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Tracing enabled; a rising edge restarts capture |
| loop_filter | input | 1 | 1 = drop repeated source addresses, 0 = write every beat |
| cof_valid | input | 1 | Change-of-flow beat present |
| cof_ready | output | 1 | Always high; the beat is taken on this edge |
| cof_kind | input | 2 | 01 source, 10 destination, 11 vector, 00 reserved |
| cof_addr | input | ADDR_W | Change-of-flow address |
| ram_we | output | 1 | Trace RAM write strobe |
| ram_waddr | output | PTR_W | Trace RAM write row |
| ram_wdata | output | ADDR_W+2 | Row contents `{kind, addr}` |
| wr_ptr | output | PTR_W | Next slot to be written |
| entry_count | output | CNT_W | Valid rows in the ring, saturating at DEPTH |
| wrapped | output | 1 | Ring has rolled over since arming |

## Verification
The bench builds the block with ADDR_W = 16 and DEPTH = 8. With eight rows, a dozen beats take the pointer through its roll-over. That brings the wrap flag and count saturation within reach, together with re-arming after a wrap, in a short vector table. A 16-bit address field is wide enough to tell vector, destination and source addresses apart. With it the bench can show that filtering is keyed on the exact address and not on the kind of the last row.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

  typedef enum logic [1:0] {
    KIND_RSVD = 2'b00,
    KIND_SRC  = 2'b01,
    KIND_DST  = 2'b10,
    KIND_VEC  = 2'b11
  } cof_kind_e;

  function automatic logic kind_is_legal(input logic [1:0] k);
    return k != KIND_RSVD;
  endfunction

  function automatic logic kind_is_source(input logic [1:0] k);
    return k == KIND_SRC;
  endfunction

endpackage

// File: rtl/cof_arm_ctrl.sv
module cof_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic beat_in,
  output logic restart,
  output logic beat_live
);

  logic arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm;
  end

  // A rising arm edge starts a fresh capture in the same cycle
  assign restart   = arm & ~arm_q;
  assign beat_live = beat_in & arm;

endmodule

// File: rtl/cof_dup_filter.sv
module cof_dup_filter
  import cof_trace_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              filt_en,
  input  logic              restart,
  output logic              keep
);

  logic [ADDR_W-1:0] last_q;
  logic              last_v_q;
  logic              shadow_live;
  logic              repeat_hit;
  logic              drop_src;

  always_comb begin
    shadow_live = last_v_q & ~restart;
    repeat_hit  = shadow_live && (addr == last_q);
    drop_src    = filt_en && kind_is_source(kind) && repeat_hit;
    keep        = beat && kind_is_legal(kind) && !drop_src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q   <= '0;
      last_v_q <= 1'b0;
    end else if (keep) begin
      last_q   <= addr;
      last_v_q <= 1'b1;
    end else if (restart) begin
      last_v_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cof_ring_ptr.sv
module cof_ring_ptr #(
  parameter int DEPTH = 64,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             adv,
  output logic [PTR_W-1:0] slot,
  output logic [PTR_W-1:0] ptr,
  output logic [CNT_W-1:0] count,
  output logic             wrapped
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam bit               POW2      = (DEPTH == (1 << PTR_W));

  logic [PTR_W-1:0] ptr_q, base_ptr, next_ptr;
  logic [CNT_W-1:0] cnt_q, base_cnt;
  logic             wrap_q, base_wrap, at_end;

  always_comb begin
    base_ptr  = restart ? '0 : ptr_q;
    base_cnt  = restart ? '0 : cnt_q;
    base_wrap = restart ? 1'b0 : wrap_q;
    at_end    = (base_ptr == LAST_SLOT);
  end

  generate
    if (POW2) begin : g_pow2
      assign next_ptr = base_ptr + 1'b1;
    end else begin : g_mod
      assign next_ptr = at_end ? '0 : base_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      ptr_q  <= adv ? next_ptr : base_ptr;
      cnt_q  <= (adv && base_cnt != FULL_CNT) ? base_cnt + 1'b1 : base_cnt;
      wrap_q <= base_wrap | (adv & at_end);
    end
  end

  assign slot    = base_ptr;
  assign ptr     = ptr_q;
  assign count   = cnt_q;
  assign wrapped = wrap_q;

endmodule

// File: rtl/cof_ram_port.sv
module cof_ram_port #(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 6,
  localparam int ROW_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [PTR_W-1:0]  slot,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic [PTR_W-1:0]  waddr,
  output logic [ROW_W-1:0]  wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we <= wr;
      if (wr) begin
        waddr <= slot;
        wdata <= {kind, addr};
      end
    end
  end

endmodule

// File: rtl/cof_trace_filter.sv
module cof_trace_filter #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ROW_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              loop_filter,
  input  logic              cof_valid,
  output logic              cof_ready,
  input  logic [1:0]        cof_kind,
  input  logic [ADDR_W-1:0] cof_addr,
  output logic              ram_we,
  output logic [PTR_W-1:0]  ram_waddr,
  output logic [ROW_W-1:0]  ram_wdata,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [CNT_W-1:0]  entry_count,
  output logic              wrapped
);

  logic             restart;
  logic             beat_live;
  logic             keep;
  logic [PTR_W-1:0] slot;

  // No back-pressure: every beat is taken when presented
  assign cof_ready = 1'b1;

  cof_arm_ctrl u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .beat_in   (cof_valid),
    .restart   (restart),
    .beat_live (beat_live)
  );

  cof_dup_filter #(.ADDR_W(ADDR_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat_live),
    .kind    (cof_kind),
    .addr    (cof_addr),
    .filt_en (loop_filter),
    .restart (restart),
    .keep    (keep)
  );

  cof_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (keep),
    .slot    (slot),
    .ptr     (wr_ptr),
    .count   (entry_count),
    .wrapped (wrapped)
  );

  cof_ram_port #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_port (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (keep),
    .slot  (slot),
    .kind  (cof_kind),
    .addr  (cof_addr),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata)
  );

endmodule

// File: rtl/cof_trace_filter_chk.sv
module cof_trace_filter_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ROW_W = ADDR_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              loop_filter,
  input logic              cof_valid,
  input logic              cof_ready,
  input logic [1:0]        cof_kind,
  input logic [ADDR_W-1:0] cof_addr,
  input logic              ram_we,
  input logic [PTR_W-1:0]  ram_waddr,
  input logic [ROW_W-1:0]  ram_wdata,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [CNT_W-1:0]  entry_count,
  input logic              wrapped
);

  // R2
  write_from_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(cof_valid && cof_ready && arm));

  // R4
  dst_vec_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cof_valid && arm && cof_kind[1]) |=>
      (ram_we && ram_wdata[ROW_W-1 -: 2] == $past(cof_kind) &&
       ram_wdata[ADDR_W-1:0] == $past(cof_addr)));

  // R6
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !ram_we);

  // R11
  reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cof_valid && cof_kind == 2'b00) |=> !ram_we);

  // R8
  ptr_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr_ptr == ((ram_waddr == PTR_W'(DEPTH - 1)) ? '0 : ram_waddr + 1'b1)));

  // R8
  wrap_on_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> (ram_we && ram_waddr == PTR_W'(DEPTH - 1)));

  // R9
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_count <= CNT_W'(DEPTH));

  // R5
  normal_mode_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cof_valid && arm && !loop_filter && cof_kind != 2'b00) |=> ram_we);

endmodule

bind cof_trace_filter cof_trace_filter_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm         (arm),
  .loop_filter (loop_filter),
  .cof_valid   (cof_valid),
  .cof_ready   (cof_ready),
  .cof_kind    (cof_kind),
  .cof_addr    (cof_addr),
  .ram_we      (ram_we),
  .ram_waddr   (ram_waddr),
  .ram_wdata   (ram_wdata),
  .wr_ptr      (wr_ptr),
  .entry_count (entry_count),
  .wrapped     (wrapped)
);

// File: tb/tb_cof_trace_filter.sv
module tb_cof_trace_filter;

  localparam int ADDR_W = 16;
  localparam int DEPTH  = 8;
  localparam int PTR_W  = 3;
  localparam int CNT_W  = 4;
  localparam int ROW_W  = ADDR_W + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              arm, loop_filter, cof_valid, cof_ready;
  logic [1:0]        cof_kind;
  logic [ADDR_W-1:0] cof_addr;
  logic              ram_we;
  logic [PTR_W-1:0]  ram_waddr;
  logic [ROW_W-1:0]  ram_wdata;
  logic [PTR_W-1:0]  wr_ptr;
  logic [CNT_W-1:0]  entry_count;
  logic              wrapped;

  cof_trace_filter #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .loop_filter(loop_filter),
    .cof_valid(cof_valid), .cof_ready(cof_ready), .cof_kind(cof_kind),
    .cof_addr(cof_addr), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .wr_ptr(wr_ptr), .entry_count(entry_count),
    .wrapped(wrapped)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [3:0]  req;
    logic        arm;
    logic        filt;
    logic        vld;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic        we;
    logic [2:0]  waddr;
    logic [2:0]  ptr;
    logic [3:0]  cnt;
    logic        wrap;
  } vec_t;

  // Kind codes: 01 source, 10 destination, 11 vector, 00 reserved
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    // R7 first beat after arming lands in slot 0
    '{4'd7,  1'b1, 1'b1, 1'b1, 2'b01, 16'h1000, 1'b1, 3'd0, 3'd1, 4'd1, 1'b0},
    // R3 repeated source dropped
    '{4'd3,  1'b1, 1'b1, 1'b1, 2'b01, 16'h1000, 1'b0, 3'd0, 3'd1, 4'd1, 1'b0},
    '{4'd3,  1'b1, 1'b1, 1'b1, 2'b01, 16'h1000, 1'b0, 3'd0, 3'd1, 4'd1, 1'b0},
    // R2 destination written
    '{4'd2,  1'b1, 1'b1, 1'b1, 2'b10, 16'h2000, 1'b1, 3'd1, 3'd2, 4'd2, 1'b0},
    // R4 repeated destination and vector still written
    '{4'd4,  1'b1, 1'b1, 1'b1, 2'b10, 16'h2000, 1'b1, 3'd2, 3'd3, 4'd3, 1'b0},
    '{4'd4,  1'b1, 1'b1, 1'b1, 2'b11, 16'hFFF2, 1'b1, 3'd3, 3'd4, 4'd4, 1'b0},
    '{4'd4,  1'b1, 1'b1, 1'b1, 2'b11, 16'hFFF2, 1'b1, 3'd4, 3'd5, 4'd5, 1'b0},
    // R4 shadow follows a vector row, so a matching source is dropped
    '{4'd4,  1'b1, 1'b1, 1'b1, 2'b01, 16'hFFF2, 1'b0, 3'd0, 3'd5, 4'd5, 1'b0},
    // R8 new source advances pointer
    '{4'd8,  1'b1, 1'b1, 1'b1, 2'b01, 16'h1000, 1'b1, 3'd5, 3'd6, 4'd6, 1'b0},
    // R5 normal mode writes a repeated source
    '{4'd5,  1'b1, 1'b0, 1'b1, 2'b01, 16'h1000, 1'b1, 3'd6, 3'd7, 4'd7, 1'b0},
    // R2 valid low writes nothing
    '{4'd2,  1'b1, 1'b1, 1'b0, 2'b01, 16'h1000, 1'b0, 3'd0, 3'd7, 4'd7, 1'b0},
    // R8 write to last slot rolls pointer and sets wrap
    '{4'd8,  1'b1, 1'b1, 1'b1, 2'b01, 16'h4000, 1'b1, 3'd7, 3'd0, 4'd8, 1'b1},
    // R9 count saturates at DEPTH
    '{4'd9,  1'b1, 1'b1, 1'b1, 2'b10, 16'h4000, 1'b1, 3'd0, 3'd1, 4'd8, 1'b1},
    // R6 disarmed beat ignored
    '{4'd6,  1'b0, 1'b1, 1'b1, 2'b01, 16'h5000, 1'b0, 3'd0, 3'd1, 4'd8, 1'b1},
    // R7 re-arm restarts capture
    '{4'd7,  1'b1, 1'b1, 1'b1, 2'b01, 16'h5000, 1'b1, 3'd0, 3'd1, 4'd1, 1'b0},
    // R3 dropped after re-arm
    '{4'd3,  1'b1, 1'b1, 1'b1, 2'b01, 16'h5000, 1'b0, 3'd0, 3'd1, 4'd1, 1'b0},
    // R11 reserved kind dropped
    '{4'd11, 1'b1, 1'b1, 1'b1, 2'b00, 16'h6000, 1'b0, 3'd0, 3'd1, 4'd1, 1'b0},
    // R2 destination after reserved
    '{4'd2,  1'b1, 1'b1, 1'b1, 2'b10, 16'h6000, 1'b1, 3'd1, 3'd2, 4'd2, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic f, input logic v,
                      input logic [1:0] k, input logic [15:0] ad);
    arm = a; loop_filter = f; cof_valid = v; cof_kind = k; cof_addr = ad;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_row(input string req, input logic [2:0] wa,
                            input logic [1:0] k, input logic [15:0] ad);
    chk(req, "ram_we", 32'(ram_we), 32'd1);
    chk(req, "ram_waddr", 32'(ram_waddr), 32'(wa));
    chk(req, "ram_wdata", 32'(ram_wdata), 32'({k, ad}));
  endtask

  initial begin
    rst_n = 1'b0; arm = 1'b0; loop_filter = 1'b1; cof_valid = 1'b0;
    cof_kind = 2'b00; cof_addr = '0;
    repeat (3) @(negedge clk);
    // R10 state during reset; R1 ready high in reset
    chk("R10", "ram_we", 32'(ram_we), 32'd0);
    chk("R10", "wr_ptr", 32'(wr_ptr), 32'd0);
    chk("R10", "entry_count", 32'(entry_count), 32'd0);
    chk("R10", "wrapped", 32'(wrapped), 32'd0);
    chk("R1", "cof_ready", 32'(cof_ready), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      step(TBL[i].arm, TBL[i].filt, TBL[i].vld, TBL[i].kind, TBL[i].addr);
      chk(tag, "ram_we", 32'(ram_we), 32'(TBL[i].we));
      if (TBL[i].we) begin
        chk(tag, "ram_waddr", 32'(ram_waddr), 32'(TBL[i].waddr));
        chk(tag, "ram_wdata", 32'(ram_wdata), 32'({TBL[i].kind, TBL[i].addr}));
      end
      chk(tag, "wr_ptr", 32'(wr_ptr), 32'(TBL[i].ptr));
      chk(tag, "entry_count", 32'(entry_count), 32'(TBL[i].cnt));
      chk(tag, "wrapped", 32'(wrapped), 32'(TBL[i].wrap));
      chk("R1", "cof_ready", 32'(cof_ready), 32'd1);
    end

    // R12 interrupt during jump: destination, vector, return destination, sources
    step(1'b1, 1'b1, 1'b1, 2'b10, 16'h7000);
    expect_row("R12", 3'd2, 2'b10, 16'h7000);
    step(1'b1, 1'b1, 1'b1, 2'b11, 16'hFFF2);
    expect_row("R12", 3'd3, 2'b11, 16'hFFF2);
    step(1'b1, 1'b1, 1'b1, 2'b10, 16'h7004);
    expect_row("R12", 3'd4, 2'b10, 16'h7004);
    // R3 source equal to the return destination is dropped
    step(1'b1, 1'b1, 1'b1, 2'b01, 16'h7004);
    chk("R3", "ram_we", 32'(ram_we), 32'd0);
    step(1'b1, 1'b1, 1'b1, 2'b01, 16'h7010);
    expect_row("R12", 3'd5, 2'b01, 16'h7010);
    chk("R12", "wr_ptr", 32'(wr_ptr), 32'd6);
    chk("R12", "entry_count", 32'(entry_count), 32'd6);

    // R10 reset in mid-run clears state even with a beat present
    rst_n = 1'b0;
    step(1'b1, 1'b1, 1'b1, 2'b10, 16'h8000);
    chk("R10", "ram_we", 32'(ram_we), 32'd0);
    chk("R10", "wr_ptr", 32'(wr_ptr), 32'd0);
    chk("R10", "entry_count", 32'(entry_count), 32'd0);
    chk("R10", "wrapped", 32'(wrapped), 32'd0);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 2'b01, 16'h7010);
    expect_row("R10", 3'd0, 2'b01, 16'h7010);
    chk("R10", "wr_ptr", 32'(wr_ptr), 32'd1);
    step(1'b1, 1'b1, 1'b0, 2'b00, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule